// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Latch Readback

This block is an eight-pin general-purpose port. Each pin owns one output latch bit. A latch bit at 0 turns on a strong pull-down, so the pad is held low. A latch bit at 1 turns the pull-down off, and the pad then rests high through a weak pull-up. An outside source can still pull that pad low, which lets software use the same pin as an input once a 1 has been stored in its latch.

The processor side has two read strobes. One returns the level at the pads and the other returns the contents of the latches. There is a plain byte write. Byte-wide read-modify-write operations (AND, OR, XOR, invert, increment, decrement) and single-bit operations (set, clear, invert, load a given value) always start from the latch contents and never from the pad level. Every update completes in one clock, so a latch read in the next cycle sees the new value.

A parameter builds an open-drain version with no internal pull-up. In that version a pin whose latch holds 1 and that nothing outside drives is reported as floating, and it reads as 0. The pads are modelled as resolved levels, not as electrical nets.

Top module: `qb_port`

## Requirements
- R1: Reset loads every latch bit with 1. With no strobes after reset, a latch read returns FFh, every pull-down is off, and in the default build every pull-up is on.
- R2: When `wr_en` is high at a clock edge, the latch takes `wr_data` at that edge. A read in the same cycle still returns the old contents, and the new value is visible from the next cycle on.
- R3: `rd_pin` high places the pad levels on `rd_data`. Otherwise `rd_latch` high places the latch on `rd_data`. With neither strobe high, `rd_data` is 00h. `rd_pin` takes priority over `rd_latch`.
- R4: A latch bit at 0 sets its `pull_dn` bit and forces its pad level to 0, whatever the outside drives.
- R5: In the default build, a latch bit at 1 gives pad level `ext_val` where `ext_en` is set and 1 where `ext_en` is clear. `pull_up` equals the latch and `pad_float` is 0.
- R6: With `OPEN_DRAIN`=1, `pull_up` is 0. A latch bit at 1 with `ext_en` clear sets `pad_float` and reads as pad level 0. With `ext_en` set, it reads `ext_val`.
- R7: `rmw_en` applies `rmw_op` to the latch and `rmw_arg`, never to the pad level. The codes are 0 AND, 1 OR, 2 XOR, 3 invert the latch, 4 add 1 modulo 256, 5 subtract 1 modulo 256, and 6 and 7 leave the latch unchanged. For example, 55h XOR FFh gives AAh.
- R8: `bit_en` applies `bit_op` to latch bit `bit_sel` only. The codes are 0 set, 1 clear, 2 invert, 3 load `bit_val`. The other seven bits keep their values.
- R9: When update strobes coincide, the byte write wins over read-modify-write, and read-modify-write wins over the bit operation. Only the winning operation takes effect.
- R10: The latch holds its value in every cycle in which no update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| rmw_en | input | 1 | Byte read-modify-write strobe |
| rmw_op | input | 3 | Read-modify-write operation code |
| rmw_arg | input | 8 | Read-modify-write operand |
| bit_en | input | 1 | Single-bit operation strobe |
| bit_op | input | 2 | Single-bit operation code |
| bit_sel | input | 3 | Index of the addressed latch bit |
| bit_val | input | 1 | Value stored by the bit load operation |
| ext_en | input | 8 | Per pin: an outside source drives the pad |
| ext_val | input | 8 | Per pin: level of the outside source |
| rd_pin | input | 1 | Read the pad levels |
| rd_latch | input | 1 | Read the latch contents |
| pull_dn | output | 8 | Per pin: strong pull-down is on |
| pull_up | output | 8 | Per pin: weak pull-up is on |
| pad_lvl | output | 8 | Per pin: resolved pad level |
| pad_float | output | 8 | Per pin: pad is undriven |
| rd_data | output | 8 | Read data to the processor |

## Verification
Two functions can fall in the same cycle. A latch update can coincide with a latch read, and two update strobes can coincide. The bench raises `rd_latch` during the cycle in which a bit operation is pending and expects the old byte, then expects the new byte one cycle later. Separately, it raises all three update strobes together, and then only the read-modify-write and bit strobes. After each of these, it reads the latch back and compares it with the operation that should have won.

// File: rtl/qb_port.sv
module qb_port #(
  parameter int W = 8,
  parameter bit OPEN_DRAIN = 1'b0,
  parameter logic [W-1:0] RST_VAL = '1,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rmw_en,
  input  logic [2:0]    rmw_op,
  input  logic [W-1:0]  rmw_arg,
  input  logic          bit_en,
  input  logic [1:0]    bit_op,
  input  logic [SW-1:0] bit_sel,
  input  logic          bit_val,
  input  logic [W-1:0]  ext_en,
  input  logic [W-1:0]  ext_val,
  input  logic          rd_pin,
  input  logic          rd_latch,
  output logic [W-1:0]  pull_dn,
  output logic [W-1:0]  pull_up,
  output logic [W-1:0]  pad_lvl,
  output logic [W-1:0]  pad_float,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] latch_q;
  logic [W-1:0] rmw_res;
  logic [W-1:0] bit_res;
  logic [W-1:0] latch_d;

  always_comb begin
    case (rmw_op)
      3'd0:    rmw_res = latch_q & rmw_arg;
      3'd1:    rmw_res = latch_q | rmw_arg;
      3'd2:    rmw_res = latch_q ^ rmw_arg;
      3'd3:    rmw_res = ~latch_q;
      3'd4:    rmw_res = latch_q + 1'b1;
      3'd5:    rmw_res = latch_q - 1'b1;
      default: rmw_res = latch_q;
    endcase
  end

  always_comb begin
    bit_res = latch_q;
    if (int'(bit_sel) < W) begin
      case (bit_op)
        2'd0: bit_res[bit_sel] = 1'b1;
        2'd1: bit_res[bit_sel] = 1'b0;
        2'd2: bit_res[bit_sel] = ~latch_q[bit_sel];
        default: bit_res[bit_sel] = bit_val;
      endcase
    end
  end

  assign latch_d = wr_en  ? wr_data :
                   rmw_en ? rmw_res :
                   bit_en ? bit_res : latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= RST_VAL;
    else        latch_q <= latch_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pull_dn[i]   = ~latch_q[i];
    assign pull_up[i]   = latch_q[i] & ~OPEN_DRAIN;
    assign pad_float[i] = latch_q[i] & ~ext_en[i] & OPEN_DRAIN;
    assign pad_lvl[i]   = latch_q[i] & (ext_en[i] ? ext_val[i] : ~OPEN_DRAIN);
  end

  assign rd_data = rd_pin   ? pad_lvl :
                   rd_latch ? latch_q : '0;

endmodule

module qb_port_chk #(
  parameter int W = 8,
  parameter bit OPEN_DRAIN = 1'b0,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [W-1:0]  wr_data,
  input logic          rmw_en,
  input logic [2:0]    rmw_op,
  input logic [W-1:0]  rmw_arg,
  input logic          bit_en,
  input logic [SW-1:0] bit_sel,
  input logic [W-1:0]  latch_q,
  input logic [W-1:0]  pad_lvl,
  input logic [W-1:0]  pad_float,
  input logic [W-1:0]  pull_up
);

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> latch_q == $past(wr_data));

  p_xor_from_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && !wr_en && rmw_op == 3'd2) |=> latch_q == ($past(latch_q) ^ $past(rmw_arg)));

  p_bit_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !wr_en && !rmw_en) |=>
      $countones((latch_q ^ $past(latch_q)) & ~(W'(1) << $past(bit_sel))) == 0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rmw_en && !bit_en) |=> $stable(latch_q));

  p_low_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_lvl & ~latch_q) == '0);

  p_float_only_od_r6: assert property (@(posedge clk) disable iff (!rst_n)
    OPEN_DRAIN ? (pull_up == '0) : (pad_float == '0));

endmodule

bind qb_port qb_port_chk #(.W(W), .OPEN_DRAIN(OPEN_DRAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg),
  .bit_en(bit_en), .bit_sel(bit_sel), .latch_q(latch_q),
  .pad_lvl(pad_lvl), .pad_float(pad_float), .pull_up(pull_up)
);

// File: tb/qb_port_tb.sv
module qb_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en = 0, rmw_en = 0, bit_en = 0, bit_val = 0, rd_pin = 0, rd_latch = 0;
  logic [7:0] wr_data = 0, rmw_arg = 0, ext_en = 0, ext_val = 0;
  logic [2:0] rmw_op = 0, bit_sel = 0;
  logic [1:0] bit_op = 0;
  logic [7:0] pdn_q, pup_q, lvl_q, flt_q, rd_q;
  logic [7:0] pdn_o, pup_o, lvl_o, flt_o, rd_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m;

  qb_port u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg), .bit_en(bit_en),
    .bit_op(bit_op), .bit_sel(bit_sel), .bit_val(bit_val), .ext_en(ext_en),
    .ext_val(ext_val), .rd_pin(rd_pin), .rd_latch(rd_latch), .pull_dn(pdn_q),
    .pull_up(pup_q), .pad_lvl(lvl_q), .pad_float(flt_q), .rd_data(rd_q));

  qb_port #(.OPEN_DRAIN(1'b1)) u_od (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg),
    .bit_en(bit_en), .bit_op(bit_op), .bit_sel(bit_sel), .bit_val(bit_val),
    .ext_en(ext_en), .ext_val(ext_val), .rd_pin(rd_pin), .rd_latch(rd_latch),
    .pull_dn(pdn_o), .pull_up(pup_o), .pad_lvl(lvl_o), .pad_float(flt_o),
    .rd_data(rd_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rmw_model(input logic [7:0] l, input logic [2:0] op, input logic [7:0] a);
    case (op)
      3'd0: return l & a;
      3'd1: return l | a;
      3'd2: return l ^ a;
      3'd3: return ~l;
      3'd4: return l + 8'd1;
      3'd5: return l - 8'd1;
      default: return l;
    endcase
  endfunction

  function automatic logic [7:0] bit_model(input logic [7:0] l, input logic [1:0] op, input int s, input logic v);
    logic [7:0] r = l;
    case (op)
      2'd0: r[s] = 1'b1;
      2'd1: r[s] = 1'b0;
      2'd2: r[s] = ~l[s];
      default: r[s] = v;
    endcase
    return r;
  endfunction

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read_latch(output logic [7:0] a, output logic [7:0] b);
    rd_pin = 0; rd_latch = 1; #1;
    a = rd_q; b = rd_o;
    rd_latch = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, e;
    logic [7:0] args [4] = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
    logic [7:0] seeds [4] = '{8'h00, 8'hFF, 8'h55, 8'hA3};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    read_latch(a, b);
    chk("R1 latch", a, 8'hFF); chk("R1 latch od", b, 8'hFF);
    chk("R1 pull_dn", pdn_q, 8'h00); chk("R1 pull_up", pup_q, 8'hFF);
    // R3 no strobe gives zero, pin priority
    #1 chk("R3 idle", rd_q, 8'h00);
    pulse_wr(8'h3C);
    ext_en = 8'hFF; ext_val = 8'h0F;
    rd_pin = 1; rd_latch = 1; #1;
    chk("R3 pin priority", rd_q, 8'h0C);
    rd_pin = 0; #1 chk("R3 latch path", rd_q, 8'h3C);
    rd_latch = 0;

    // R4 R5 R6 sweep of all latch values and several drive patterns
    for (int l = 0; l < 256; l++) begin
      pulse_wr(8'(l));
      for (int p = 0; p < 4; p++) begin
        ext_en  = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'(l * 37 + p);
        ext_val = (p == 3) ? 8'(l ^ 8'h96) : 8'(l * 11 + 5);
        rd_pin = 1; #1;
        e = 8'(l) & ((ext_en & ext_val) | ~ext_en);
        chk("R5 quasi pad", rd_q, e);
        chk("R4 pull_dn", pdn_q, ~8'(l));
        chk("R6 od pad", rd_o, 8'(l) & ext_en & ext_val);
        chk("R6 od float", flt_o, 8'(l) & ~ext_en);
        chk("R6 od pull_up", pup_o, 8'h00);
        chk("R5 pull_up", pup_q, 8'(l));
        rd_pin = 0;
      end
    end

    // R7 byte read-modify-write from the latch; pads driven against it
    ext_en = 8'hFF; ext_val = 8'h00;
    for (int l = 0; l < 256; l++) begin
      for (int op = 0; op < 8; op++) begin
        for (int k = 0; k < 4; k++) begin
          if (op >= 3 && k > 0) continue;
          pulse_wr(8'(l));
          @(negedge clk); rmw_en = 1; rmw_op = 3'(op); rmw_arg = args[k];
          @(negedge clk); rmw_en = 0;
          read_latch(a, b);
          e = rmw_model(8'(l), 3'(op), args[k]);
          chk("R7 rmw", a, e);
          chk("R7 rmw od", b, e);
        end
      end
    end
    pulse_wr(8'h55);
    @(negedge clk); rmw_en = 1; rmw_op = 3'd2; rmw_arg = 8'hFF;
    @(negedge clk); rmw_en = 0;
    read_latch(a, b); chk("R7 55 xor ff", a, 8'hAA);
    ext_en = 8'h00;

    // R8 bit operations on every position
    for (int si = 0; si < 4; si++)
      for (int s = 0; s < 8; s++)
        for (int op = 0; op < 4; op++)
          for (int v = 0; v < 2; v++) begin
            pulse_wr(seeds[si]);
            @(negedge clk); bit_en = 1; bit_op = 2'(op); bit_sel = 3'(s); bit_val = v[0];
            @(negedge clk); bit_en = 0;
            read_latch(a, b);
            chk("R8 bit op", a, bit_model(seeds[si], 2'(op), s, v[0]));
          end

    // R2 same-cycle read sees old value, next cycle new
    pulse_wr(8'h0F);
    @(negedge clk); bit_en = 1; bit_op = 2'd0; bit_sel = 3'd7;
    rd_latch = 1; #1 chk("R2 old during update", rd_q, 8'h0F);
    @(negedge clk); bit_en = 0; #1 chk("R2 new after update", rd_q, 8'h8F);
    rd_latch = 0;

    // R9 priority
    pulse_wr(8'h11);
    @(negedge clk); wr_en = 1; wr_data = 8'hE7; rmw_en = 1; rmw_op = 3'd3;
    bit_en = 1; bit_op = 2'd1; bit_sel = 3'd0;
    @(negedge clk); wr_en = 0; rmw_en = 0; bit_en = 0;
    read_latch(a, b); chk("R9 write wins", a, 8'hE7);
    @(negedge clk); rmw_en = 1; rmw_op = 3'd1; rmw_arg = 8'h08;
    bit_en = 1; bit_op = 2'd1; bit_sel = 3'd0;
    @(negedge clk); rmw_en = 0; bit_en = 0;
    read_latch(a, b); chk("R9 rmw over bit", a, 8'hEF);

    // R10 hold with no strobes, pads changing
    ext_en = 8'hFF; ext_val = 8'h00;
    repeat (5) @(negedge clk);
    read_latch(a, b); chk("R10 hold", a, 8'hEF);
    ext_en = 8'h00;

    // R1 reset again after activity
    pulse_wr(8'h00);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    read_latch(a, b); chk("R1 re-reset", a, 8'hFF); chk("R1 re-reset od", b, 8'hFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule